// File: doc/BRIEF.md
# Multi-core global timer comparator

This block keeps one 64-bit up-counter that all processor cores share, plus a private comparator for every core. The counter advances on a divided version of an input tick: a shared 8-bit divider value P makes it step once for every P+1 ticks while the shared run bit is set. Each core programs its own 64-bit compare value, an optional auto-increment step, and three control bits of its own: compare enable, interrupt enable and auto-increment enable. When the counter has reached the compare value, the core's sticky status flag is set. The flag drives that core's interrupt line when the core's interrupt enable is set.

Software uses 32-bit word accesses in a 32-byte window. Every request carries the number of the requesting core. The core number picks which set of private registers a control, status, compare or increment access reaches. When auto-increment is on, a compare hit moves the compare value forward by whole steps until it is strictly ahead of the counter. The steps are taken over a few clock cycles, as a shifted-step search, so that no divider is needed.

Top module: `gtm_global_timer`

## Requirements
- R1: While the run bit is clear, the counter can be written and read as two 32-bit halves: the low half at offset 0x00 and the high half at offset 0x04.
- R2: While the run bit is set, the counter advances by one for every P+1 cycles with `tick_i` high, where P is control bits 15:8 (the divider restarts at 0 each time the run bit is set). While the run bit is clear, ticks do not move the counter.
- R3: The control register is at offset 0x08. Bit 0 is run and bits 15:8 are the divider; both are shared by all cores. Bit 1 (compare enable), bit 2 (interrupt enable) and bit 3 (auto-increment) are private to each core. A read returns the shared fields merged with the requester's private bits, and all other bits read as zero.
- R4: When run and the core's compare enable are both set and the counter is greater than or equal to the core's compare value, the core's status flag (bit 0 at offset 0x0C) is set.
- R5: With auto-increment off, a compare hit leaves the compare value (0x10 low half, 0x14 high half) unchanged, and the hit keeps the flag set for as long as the condition holds.
- R6: With auto-increment on and a nonzero step (offset 0x18), a hit raises the compare value to the smallest value of the form compare + k*step, with k at least 1, that is greater than the counter. A zero step leaves the compare value unchanged.
- R7: Writing to the status offset clears the requester's flag when data bit 0 is 1, and leaves it unchanged when bit 0 is 0. A hit in the same cycle takes priority over the clear.
- R8: `irq_o[c]` is high exactly when core c's status flag and interrupt enable are both set.
- R9: While the run bit is set, writes to 0x00 and 0x04 do not change the counter.
- R10: An access to a misaligned byte address or to offset 0x1C reads as zero and changes nothing.
- R11: After reset the counter, the divider, all control bits, compare values, steps and status flags read as zero, and every interrupt line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Counting tick, one count per high cycle before division |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_core_i | input | CORE_W | Number of the requesting core |
| req_addr_i | input | 5 | Byte offset in the register window |
| req_wdata_i | input | 32 | Write data |
| req_rdata_o | output | 32 | Read data, valid in the cycle of the read request |
| irq_o | output | NUM_CPU | Per-core interrupt lines |

## Verification
If the divider phase is wrong, the counter reads back one count high or low after a burst of ticks, as soon as the run bit is cleared and the counter is read. If the comparison or the catch-up adder is wrong, the readback compare value after a catch-up differs from the exact multiple-of-step target. It also shows as a status flag or interrupt line that disagrees with the counter-versus-compare relation one cycle after the timer starts. A leak between the private register sets appears in the merged control readback and in the other core's interrupt line, which must stay low.

// File: rtl/gtm_pkg.sv
package gtm_pkg;
  // Word index (byte address bits 4:2) of each register.
  localparam logic [2:0] WI_CNT_LO = 3'd0;
  localparam logic [2:0] WI_CNT_HI = 3'd1;
  localparam logic [2:0] WI_CTRL   = 3'd2;
  localparam logic [2:0] WI_STAT   = 3'd3;
  localparam logic [2:0] WI_CMP_LO = 3'd4;
  localparam logic [2:0] WI_CMP_HI = 3'd5;
  localparam logic [2:0] WI_STEP   = 3'd6;

  // Control bit positions.
  localparam int unsigned CB_RUN     = 0;
  localparam int unsigned CB_CMP_EN  = 1;
  localparam int unsigned CB_IRQ_EN  = 2;
  localparam int unsigned CB_AUTO    = 3;
  localparam int unsigned CB_DIV_LSB = 8;

  typedef struct packed {
    logic auto_inc;
    logic irq_en;
    logic cmp_en;
  } bank_ctrl_t;
endpackage

// File: rtl/gtm_prescale.sv
module gtm_prescale #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] limit_i,
  output logic             adv_o
);
  logic [DIV_W-1:0] phase_q, phase_d;

  assign adv_o = run_i && tick_i && (phase_q >= limit_i);

  always_comb begin
    phase_d = phase_q;
    if (!run_i) begin
      phase_d = '0;
    end else if (tick_i) begin
      phase_d = adv_o ? '0 : phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  // R2: a tick below the limit moves the phase by exactly one
  p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && tick_i && phase_q < limit_i) |=> phase_q == $past(phase_q) + 1'b1);

  // R2: stopped timer holds the divider at its start point
  p_phase_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> phase_q == '0);
endmodule

// File: rtl/gtm_counter.sv
module gtm_counter #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             adv_i,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [CNT_W-1:0] count_o
);
  localparam int unsigned HI_W = CNT_W - DW;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (run_i) begin
      if (adv_i) cnt_d = cnt_q + 1'b1;
    end else if (wr_lo_i) begin
      cnt_d = {cnt_q[CNT_W-1:DW], wdata_i};
    end else if (wr_hi_i) begin
      cnt_d = {wdata_i[HI_W-1:0], cnt_q[DW-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  // R9: a running counter only moves by its own advance pulse
  p_run_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !adv_i) |=> cnt_q == $past(cnt_q));

  // R2: each advance adds exactly one
  p_adv_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && adv_i) |=> cnt_q == $past(cnt_q) + 1'b1);
endmodule

// File: rtl/gtm_bank.sv
module gtm_bank
  import gtm_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             ctrl_we_i,
  input  bank_ctrl_t       ctrl_wdata_i,
  input  logic             cmp_lo_we_i,
  input  logic             cmp_hi_we_i,
  input  logic             step_we_i,
  input  logic             sts_clr_i,
  input  logic [DW-1:0]    wdata_i,
  output bank_ctrl_t       ctrl_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic [DW-1:0]    step_o,
  output logic             sts_o,
  output logic             irq_o
);
  localparam int unsigned HI_W = CNT_W - DW;

  bank_ctrl_t       ctrl_q, ctrl_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic [DW-1:0]    step_q, step_d;
  logic             sts_q, sts_d;
  logic             hit;
  logic [CNT_W-1:0] jump;

  assign hit = run_i && ctrl_q.cmp_en && (count_i >= cmp_q);

  // Largest shifted step that still lands at or below the counter;
  // the plain step when none does (that step finishes the catch-up).
  always_comb begin
    logic [CNT_W:0] cand;
    logic [CNT_W:0] base;
    base = {{(CNT_W-DW+1){1'b0}}, step_q};
    jump = {{(CNT_W-DW){1'b0}}, step_q};
    cand = '0;
    for (int j = 0; j < DW; j++) begin
      cand = {1'b0, cmp_q} + (base << j);
      if (!cand[CNT_W] && (cand[CNT_W-1:0] <= count_i)) begin
        jump = base[CNT_W-1:0] << j;
      end
    end
  end

  always_comb begin
    ctrl_d = ctrl_we_i ? ctrl_wdata_i : ctrl_q;
    step_d = step_we_i ? wdata_i : step_q;
    cmp_d  = cmp_q;
    if (cmp_lo_we_i) begin
      cmp_d = {cmp_q[CNT_W-1:DW], wdata_i};
    end else if (cmp_hi_we_i) begin
      cmp_d = {wdata_i[HI_W-1:0], cmp_q[DW-1:0]};
    end else if (hit && ctrl_q.auto_inc && (step_q != '0)) begin
      cmp_d = cmp_q + jump;
    end
    if (hit)            sts_d = 1'b1;
    else if (sts_clr_i) sts_d = 1'b0;
    else                sts_d = sts_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
      step_q <= '0;
      sts_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      cmp_q  <= cmp_d;
      step_q <= step_d;
      sts_q  <= sts_d;
    end
  end

  assign ctrl_o = ctrl_q;
  assign cmp_o  = cmp_q;
  assign step_o = step_q;
  assign sts_o  = sts_q;
  assign irq_o  = sts_q && ctrl_q.irq_en;

  // R4: the flag only rises after the compare condition held
  p_sts_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts_q && sts_d) |=> $past(run_i && ctrl_q.cmp_en && count_i >= cmp_q));

  // R5: without auto-increment a hit never moves the compare value
  p_cmp_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !ctrl_q.auto_inc && !cmp_lo_we_i && !cmp_hi_we_i) |=> $stable(cmp_q));

  // R6: an auto-increment hit with a nonzero step moves the value forward
  p_auto_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ctrl_q.auto_inc && step_q != '0 && !cmp_lo_we_i && !cmp_hi_we_i
     && cmp_q <= count_i - {{(CNT_W-DW){1'b0}}, step_q})
    |=> cmp_q > $past(cmp_q));

  // R7: a clear without a competing hit leaves the flag low
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr_i && !hit) |=> !sts_q);
endmodule

// File: rtl/gtm_global_timer.sv
module gtm_global_timer
  import gtm_pkg::*;
#(
  parameter int unsigned NUM_CPU = 2,
  parameter int unsigned CNT_W   = 64,
  parameter int unsigned DW      = 32,
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned AW      = 5,
  localparam int unsigned CORE_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [CORE_W-1:0] req_core_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DW-1:0]     req_wdata_i,
  output logic [DW-1:0]     req_rdata_o,
  output logic [NUM_CPU-1:0] irq_o
);
  localparam logic [CORE_W:0] NCPU_L = NUM_CPU[CORE_W:0];

  // Reset: asserted at once, released on the clock.
  logic [1:0] rsync_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_q = rsync_q[1];

  // Request decode.
  logic       hit, wr;
  logic [2:0] widx;
  assign widx = req_addr_i[AW-1:2];
  assign hit  = req_valid_i && (req_addr_i[1:0] == 2'b00) && (widx != 3'd7)
                && ({1'b0, req_core_i} < NCPU_L);
  assign wr   = hit && req_write_i;

  // Shared control fields.
  logic             run_q, run_d;
  logic [DIV_W-1:0] div_q, div_d;
  always_comb begin
    run_d = run_q;
    div_d = div_q;
    if (wr && widx == WI_CTRL) begin
      run_d = req_wdata_i[CB_RUN];
      div_d = req_wdata_i[CB_DIV_LSB +: DIV_W];
    end
  end
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      run_q <= 1'b0;
      div_q <= '0;
    end else begin
      run_q <= run_d;
      div_q <= div_d;
    end
  end

  logic             adv;
  logic [CNT_W-1:0] count;

  gtm_prescale #(.DIV_W(DIV_W)) u_prescale (
    .clk     (clk),
    .rst_n   (rst_q),
    .run_i   (run_q),
    .tick_i  (tick_i),
    .limit_i (div_q),
    .adv_o   (adv)
  );

  gtm_counter #(.CNT_W(CNT_W), .DW(DW)) u_counter (
    .clk     (clk),
    .rst_n   (rst_q),
    .run_i   (run_q),
    .adv_i   (adv),
    .wr_lo_i (wr && widx == WI_CNT_LO),
    .wr_hi_i (wr && widx == WI_CNT_HI),
    .wdata_i (req_wdata_i),
    .count_o (count)
  );

  bank_ctrl_t       wr_ctrl;
  assign wr_ctrl.cmp_en   = req_wdata_i[CB_CMP_EN];
  assign wr_ctrl.irq_en   = req_wdata_i[CB_IRQ_EN];
  assign wr_ctrl.auto_inc = req_wdata_i[CB_AUTO];

  bank_ctrl_t       bk_ctrl [NUM_CPU];
  logic [CNT_W-1:0] bk_cmp  [NUM_CPU];
  logic [DW-1:0]    bk_step [NUM_CPU];
  logic [NUM_CPU-1:0] bk_sts;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
    logic mine;
    assign mine = wr && (req_core_i == CORE_W'(c));

    gtm_bank #(.CNT_W(CNT_W), .DW(DW)) u_bank (
      .clk          (clk),
      .rst_n        (rst_q),
      .run_i        (run_q),
      .count_i      (count),
      .ctrl_we_i    (mine && widx == WI_CTRL),
      .ctrl_wdata_i (wr_ctrl),
      .cmp_lo_we_i  (mine && widx == WI_CMP_LO),
      .cmp_hi_we_i  (mine && widx == WI_CMP_HI),
      .step_we_i    (mine && widx == WI_STEP),
      .sts_clr_i    (mine && widx == WI_STAT && req_wdata_i[0]),
      .wdata_i      (req_wdata_i),
      .ctrl_o       (bk_ctrl[c]),
      .cmp_o        (bk_cmp[c]),
      .step_o       (bk_step[c]),
      .sts_o        (bk_sts[c]),
      .irq_o        (irq_o[c])
    );

    // R8: a core whose interrupt enable is clear keeps its line low
    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_q)
      !bk_ctrl[c].irq_en |-> !irq_o[c]);
  end

  // Read path: requester's private set, merged with the shared fields.
  bank_ctrl_t       sel_ctrl;
  logic [CNT_W-1:0] sel_cmp;
  logic [DW-1:0]    sel_step;
  logic             sel_sts;
  logic [DW-1:0]    ctrl_rd;
  always_comb begin
    sel_ctrl = '0;
    sel_cmp  = '0;
    sel_step = '0;
    sel_sts  = 1'b0;
    for (int c = 0; c < NUM_CPU; c++) begin
      if (req_core_i == CORE_W'(c)) begin
        sel_ctrl = bk_ctrl[c];
        sel_cmp  = bk_cmp[c];
        sel_step = bk_step[c];
        sel_sts  = bk_sts[c];
      end
    end
    ctrl_rd = '0;
    ctrl_rd[CB_RUN]    = run_q;
    ctrl_rd[CB_CMP_EN] = sel_ctrl.cmp_en;
    ctrl_rd[CB_IRQ_EN] = sel_ctrl.irq_en;
    ctrl_rd[CB_AUTO]   = sel_ctrl.auto_inc;
    ctrl_rd[CB_DIV_LSB +: DIV_W] = div_q;
  end

  always_comb begin
    req_rdata_o = '0;
    if (hit && !req_write_i) begin
      case (widx)
        WI_CNT_LO: req_rdata_o = count[DW-1:0];
        WI_CNT_HI: req_rdata_o = count[CNT_W-1:DW];
        WI_CTRL:   req_rdata_o = ctrl_rd;
        WI_STAT:   req_rdata_o = {{(DW-1){1'b0}}, sel_sts};
        WI_CMP_LO: req_rdata_o = sel_cmp[DW-1:0];
        WI_CMP_HI: req_rdata_o = sel_cmp[CNT_W-1:DW];
        WI_STEP:   req_rdata_o = sel_step;
        default:   req_rdata_o = '0;
      endcase
    end
  end

  // R10: reads outside the decoded registers return zero
  p_unknown_zero_r10: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid_i && !req_write_i && (req_addr_i[1:0] != 2'b00 || widx == 3'd7))
    |-> req_rdata_o == '0);

  // R1/R9: the run bit changes only through a control write
  p_run_src_r3: assert property (@(posedge clk) disable iff (!rst_q)
    !(wr && widx == WI_CTRL) |=> $stable(run_q));
endmodule

// File: tb/gtm_global_timer_tb.sv
`timescale 1ns/1ps
module gtm_global_timer_tb;
  localparam int NUM_CPU = 2;
  localparam logic [4:0] A_CLO = 5'h00, A_CHI = 5'h04, A_CTL = 5'h08,
                         A_STS = 5'h0C, A_KLO = 5'h10, A_KHI = 5'h14,
                         A_INC = 5'h18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic vld = 1'b0, wrt = 1'b0;
  logic [0:0] core = '0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NUM_CPU-1:0] irq;

  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gtm_global_timer #(.NUM_CPU(NUM_CPU)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .req_valid_i(vld),
    .req_write_i(wrt), .req_core_i(core), .req_addr_i(addr),
    .req_wdata_i(wdata), .req_rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // All tasks enter and leave at a falling edge.
  task automatic wr(input int c, input logic [4:0] a, input logic [31:0] d);
    vld = 1'b1; wrt = 1'b1; core = 1'(c); addr = a; wdata = d;
    @(negedge clk);
    vld = 1'b0; wrt = 1'b0;
  endtask

  task automatic rd(input int c, input logic [4:0] a, output logic [31:0] d);
    vld = 1'b1; wrt = 1'b0; core = 1'(c); addr = a;
    #1 d = rdata;
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic rd64(input int c, input logic [4:0] a, output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(c, a, lo);
    rd(c, a + 5'd4, hi);
    v = {hi, lo};
  endtask

  function automatic logic [31:0] ctl(input bit run, input bit ce, input bit ie,
                                      input bit au, input logic [7:0] dv);
    return {16'h0, dv, 4'h0, au, ie, ce, run};
  endfunction

  function automatic logic [63:0] next_cmp(input logic [63:0] k, input logic [63:0] c,
                                           input logic [31:0] step, input bit au);
    if (c < k || !au || step == 0) return k;
    return k + 64'(step) * ((c - k) / 64'(step) + 64'd1);
  endfunction

  // One compare scenario on core c with the counter frozen (tick low).
  task automatic cmp_case(input int c, input logic [63:0] cv, input logic [63:0] kv,
                          input logic [31:0] step, input bit au, input bit ie);
    logic [31:0] d;
    logic [63:0] v;
    bit          h;
    wr(0, A_CTL, 32'h0);
    wr(1, A_CTL, 32'h0);
    wr(0, A_STS, 32'h1);
    wr(1, A_STS, 32'h1);
    wr(c, A_CLO, cv[31:0]);
    wr(c, A_CHI, cv[63:32]);
    wr(c, A_KLO, kv[31:0]);
    wr(c, A_KHI, kv[63:32]);
    wr(c, A_INC, step);
    wr(c, A_CTL, ctl(1, 1, ie, au, 8'd0));
    idle(80);
    h = (cv >= kv);
    rd(c, A_STS, d);
    check("R4 status", 64'(d), 64'(h));
    check("R8 irq own", 64'(irq[c]), 64'(h && ie));
    check("R8 irq other", 64'(irq[1-c]), 64'd0);
    rd64(c, A_KLO, v);
    check(au ? "R6 compare catch-up" : "R5 compare hold", v, next_cmp(kv, cv, step, au));
  endtask

  initial begin
    logic [31:0] d;
    logic [63:0] v, kv, cv;
    void'($urandom(32'd20240611));
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R11: reset values
    rd(0, A_CLO, d); check("R11 cnt lo", 64'(d), 0);
    rd(0, A_CHI, d); check("R11 cnt hi", 64'(d), 0);
    rd(0, A_CTL, d); check("R11 ctrl", 64'(d), 0);
    rd(1, A_STS, d); check("R11 status", 64'(d), 0);
    rd(1, A_KLO, d); check("R11 cmp", 64'(d), 0);
    rd(0, A_INC, d); check("R11 step", 64'(d), 0);
    check("R11 irq", 64'(irq), 0);

    // R3: shared and private control fields
    wr(0, A_CTL, ctl(0, 1, 1, 0, 8'd5));
    wr(1, A_CTL, ctl(0, 0, 0, 1, 8'd7));
    rd(0, A_CTL, d); check("R3 merge core0", 64'(d), 64'(ctl(0, 1, 1, 0, 8'd7)));
    rd(1, A_CTL, d); check("R3 merge core1", 64'(d), 64'(ctl(0, 0, 0, 1, 8'd7)));
    wr(0, A_CTL, 32'hFFFF_FFF0);
    rd(1, A_CTL, d); check("R3 unused bits", 64'(d), 64'(ctl(0, 0, 0, 1, 8'hFF)));
    wr(0, A_CTL, 0); wr(1, A_CTL, 0);

    // R1: counter halves
    wr(0, A_CLO, 32'hDEAD_BEEF);
    wr(1, A_CHI, 32'h1234_5678);
    rd64(1, A_CLO, v); check("R1 counter write", v, 64'h1234_5678_DEAD_BEEF);

    // R9: writes ignored while running (ticks held low)
    wr(0, A_CTL, ctl(1, 0, 0, 0, 8'd0));
    wr(0, A_CLO, 32'h5);
    wr(1, A_CHI, 32'h9);
    rd64(0, A_CLO, v); check("R9 write while running", v, 64'h1234_5678_DEAD_BEEF);
    wr(0, A_CTL, 0);

    // R10: unknown offset and misaligned accesses
    rd(0, 5'h1C, d); check("R10 unknown read", 64'(d), 0);
    rd(0, 5'h09, d); check("R10 misaligned read", 64'(d), 0);
    wr(0, 5'h1C, 32'hFFFF_FFFF);
    wr(0, 5'h01, 32'h0);
    wr(1, 5'h0A, 32'hFFFF_FFFF);
    rd64(0, A_CLO, v); check("R10 counter untouched", v, 64'h1234_5678_DEAD_BEEF);
    rd(1, A_CTL, d); check("R10 ctrl untouched", 64'(d), 0);

    // R2: disabled timer ignores ticks
    ticks(7);
    rd64(0, A_CLO, v); check("R2 idle no count", v, 64'h1234_5678_DEAD_BEEF);

    // R2: divided counting, boundary across the low-half carry
    wr(0, A_CLO, 32'hFFFF_FFFE);
    wr(0, A_CTL, ctl(1, 0, 0, 0, 8'd0));
    ticks(3);
    wr(0, A_CTL, 0);
    rd64(0, A_CLO, v); check("R2 carry into high half", v, 64'h1234_5679_0000_0001);

    for (int it = 0; it < 24; it++) begin
      int c, p, n;
      c = int'($urandom % 2);
      p = int'($urandom % 6);
      n = int'($urandom % 30);
      wr(c, A_CLO, 32'h0);
      wr(c, A_CHI, 32'h0);
      wr(c, A_CTL, ctl(1, 0, 0, 0, 8'(p)));
      ticks(n);
      wr(c, A_CTL, 0);
      rd64(1 - c, A_CLO, v);
      check("R2 divided count", v, 64'(n / (p + 1)));
    end

    // R5/R7/R8: hit without auto-increment, clear races
    wr(0, A_CLO, 32'd100); wr(0, A_CHI, 0);
    wr(0, A_KLO, 32'd50);  wr(0, A_KHI, 0);
    wr(0, A_CTL, ctl(1, 1, 0, 0, 8'd0));
    idle(2);
    rd(0, A_STS, d); check("R4 equal-or-above hit", 64'(d), 1);
    check("R8 irq masked", 64'(irq[0]), 0);
    wr(0, A_STS, 32'h1);
    rd(0, A_STS, d); check("R7 hit beats clear", 64'(d), 1);
    wr(0, A_CTL, ctl(1, 0, 1, 0, 8'd0));
    idle(1);
    check("R8 irq enabled", 64'(irq[0]), 1);
    wr(0, A_STS, 32'h2);
    rd(0, A_STS, d); check("R7 bit0 zero keeps flag", 64'(d), 1);
    wr(0, A_STS, 32'h1);
    rd(0, A_STS, d); check("R7 clear", 64'(d), 0);
    check("R8 irq after clear", 64'(irq[0]), 0);
    rd64(0, A_KLO, v); check("R5 compare unchanged", v, 64'd50);

    // Directed compare corners
    cmp_case(1, 64'd500, 64'd500, 32'd7, 1'b1, 1'b1);        // equality
    cmp_case(0, 64'd499, 64'd500, 32'd7, 1'b1, 1'b1);        // one below
    cmp_case(1, 64'd900, 64'd500, 32'd0, 1'b1, 1'b1);        // zero step
    cmp_case(0, 64'h0000_0001_0000_0005, 64'h0000_0000_FFFF_FFF0, 32'd3, 1'b1, 1'b0);

    // Random compare scenarios
    for (int it = 0; it < 20; it++) begin
      int c;
      bit au, ie;
      logic [31:0] step;
      logic [31:0] dl;
      c  = int'($urandom % 2);
      au = 1'($urandom);
      ie = 1'($urandom);
      step = ($urandom % 4 == 0) ? 32'($urandom % 5) : ($urandom % 32'h10_0000) + 1;
      kv = {24'h0, 8'($urandom), $urandom};
      dl = $urandom % 32'h4000_0000;
      if ($urandom % 3 == 0) cv = (kv > 64'(dl)) ? kv - 64'(dl) - 1 : 64'd0;
      else                   cv = kv + 64'(dl);
      cmp_case(c, cv, kv, step, au, ie);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #1_600_000;
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule